// File: doc/BRIEF.md
# CAN Node Error Supervisor

The supervisor sits beside a CAN protocol controller and turns its error interrupts into short diagnostic reports. When the controller raises an error interrupt, the supervisor captures the error flag word, then sends one report frame per active condition. Every report uses the standard identifier 0x3FF and carries a single data byte with an error code. It sends them in a fixed priority order and waits for the transmit outcome of each frame before starting the next.

Bus-off gets special handling. The first bus-off makes the supervisor pulse a controller re-initialise request and then send a recovery report. If that report goes out, a sticky bus-off-seen flag is set and normal service resumes. If the report fails, or bus-off returns while the flag is already set, the supervisor sends a final report and then halts. It stays halted until power-on reset. A separate strobe marks an interrupt from an unrecognised source, which is reported as a system error without touching the bus-off state.

Top module: `can_err_supervisor`

## Requirements
- R1: Each report is presented with frame_req high, frame_id equal to 0x3FF and a one-byte frame_code. frame_req and frame_code hold steady until tx_done is seen high on a clock edge.
- R2: err_flags bit positions are: bit 0 receive warning (code 0x01), bit 1 transmit warning (0x02), bit 2 receive error-passive (0x03), bit 3 transmit error-passive (0x04), bit 4 bus-off, bit 5 receive-buffer-1 overflow (0x11). Flags are captured on a clock edge where err_irq is high. A single captured flag yields exactly one report with its code.
- R3: Several captured conditions are reported one frame at a time in this order: overflow, bus-off, receive error-passive, transmit error-passive, receive warning, transmit warning, system error.
- R4: A sys_irq strobe produces one report with code 0x20 and leaves busoff_seen and halted unchanged.
- R5: On a bus-off while busoff_seen is low, reinit_req is high for exactly one cycle. The recovery report with code 0x12 is presented on the next cycle.
- R6: If the 0x12 report completes with tx_ok high, busoff_seen becomes 1 and stays 1, halted stays 0, and later conditions are reported normally.
- R7: If the 0x12 report completes with tx_ok low, a report with code 0x13 follows, and after its tx_done the block is halted.
- R8: A bus-off while busoff_seen is 1 produces a 0x13 report without reinit_req, and after its tx_done the block is halted.
- R9: While halted, frame_req and reinit_req stay low and err_irq and sys_irq are ignored, until rst_n is asserted.
- R10: The tx_ok value of any report other than 0x12 has no effect on the bus-off state. tx_done while no report is pending has no effect.
- R11: After reset, frame_req, reinit_req, busoff_seen and halted are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| err_irq | input | 1 | Error interrupt strobe; err_flags valid with it |
| err_flags | input | 6 | Error flag word (positions in R2) |
| sys_irq | input | 1 | Strobe for an interrupt from an unrecognised source |
| tx_done | input | 1 | Transmit of the presented report has finished |
| tx_ok | input | 1 | With tx_done: 1 sent successfully, 0 failed |
| frame_req | output | 1 | A report frame is presented |
| frame_id | output | 11 | Standard identifier of the report |
| frame_code | output | 8 | Data byte: error code |
| reinit_req | output | 1 | One-cycle controller re-initialise request |
| busoff_seen | output | 1 | Sticky flag: a bus-off was recovered |
| halted | output | 1 | Node idled until power-on reset |

## Verification
First, each flag alone shows that the bit-to-code mapping is right. Next, flag words with several bits set, including bus-off mixed with overflow and warnings, show whether the priority order holds and whether pending conditions survive a recovery. Bus-off is then tried in three histories: first occurrence with a successful report, first occurrence with a failed report, and repeat after recovery. These tell the recovery path apart from both halting paths. Finally, system-error strobes, stray tx_done pulses, failing ordinary reports and stimulus while halted confirm that none of them disturbs the bus-off state.

// File: rtl/can_es_pkg.sv
package can_es_pkg;

  // Number of report sources, indexed in service priority (0 first)
  localparam int unsigned NSRC   = 7;
  localparam int unsigned FLAG_W = 6;

  localparam int unsigned P_OVF  = 0;
  localparam int unsigned P_BOFF = 1;
  localparam int unsigned P_RXP  = 2;
  localparam int unsigned P_TXP  = 3;
  localparam int unsigned P_RXW  = 4;
  localparam int unsigned P_TXW  = 5;
  localparam int unsigned P_SYS  = 6;

  // Error flag word bit positions
  localparam int unsigned F_RXW  = 0;
  localparam int unsigned F_TXW  = 1;
  localparam int unsigned F_RXP  = 2;
  localparam int unsigned F_TXP  = 3;
  localparam int unsigned F_BOFF = 4;
  localparam int unsigned F_OVF  = 5;

  localparam logic [7:0] C_RXW   = 8'h01;
  localparam logic [7:0] C_TXW   = 8'h02;
  localparam logic [7:0] C_RXP   = 8'h03;
  localparam logic [7:0] C_TXP   = 8'h04;
  localparam logic [7:0] C_OVF   = 8'h11;
  localparam logic [7:0] C_BOFF1 = 8'h12;
  localparam logic [7:0] C_BOFF2 = 8'h13;
  localparam logic [7:0] C_SYS   = 8'h20;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_REINIT = 2'd1,
    ST_SEND   = 2'd2,
    ST_HALT   = 2'd3
  } es_state_t;

  // Code carried by a report for a given source index
  function automatic logic [7:0] code_of(input int unsigned idx, input logic seen);
    logic [7:0] c;
    case (idx)
      P_OVF:   c = C_OVF;
      P_BOFF:  c = seen ? C_BOFF2 : C_BOFF1;
      P_RXP:   c = C_RXP;
      P_TXP:   c = C_TXP;
      P_RXW:   c = C_RXW;
      P_TXW:   c = C_TXW;
      default: c = C_SYS;
    endcase
    return c;
  endfunction

  // Reorder the flag word into priority order and append the system source
  function automatic logic [NSRC-1:0] to_prio(input logic [FLAG_W-1:0] f, input logic sys);
    logic [NSRC-1:0] p;
    p         = '0;
    p[P_OVF]  = f[F_OVF];
    p[P_BOFF] = f[F_BOFF];
    p[P_RXP]  = f[F_RXP];
    p[P_TXP]  = f[F_TXP];
    p[P_RXW]  = f[F_RXW];
    p[P_TXW]  = f[F_TXW];
    p[P_SYS]  = sys;
    return p;
  endfunction

endpackage

// File: rtl/can_es_pend.sv
module can_es_pend #(
  parameter int unsigned N = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic [N-1:0] set_vec,
  input  logic [N-1:0] clr_vec,
  output logic [N-1:0] pend
);

  // Set wins over clear so a condition re-raised during its own report is kept
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pend <= '0;
    else if (flush) pend <= '0;
    else            pend <= (pend & ~clr_vec) | set_vec;
  end

  // R3: a captured condition is never lost before it is served
  a_r3_set_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && set_vec != '0) |=> ((pend & $past(set_vec)) == $past(set_vec)));

endmodule

// File: rtl/can_es_prio.sv
module can_es_prio #(
  parameter int unsigned N  = 7,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  output logic [N-1:0]  grant,
  output logic [IW-1:0] idx,
  output logic          any
);

  logic [N:0] blk;
  assign blk[0] = 1'b0;

  genvar gi;
  generate
    for (gi = 0; gi < N; gi++) begin : g_chain
      assign blk[gi+1]  = blk[gi] | req[gi];
      assign grant[gi]  = req[gi] & ~blk[gi];
    end
  endgenerate

  assign any = blk[N];

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end

  // R3: at most one source granted, and only a requesting one
  a_r3_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  a_r3_grant_in_req: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~req) == '0);

endmodule

// File: rtl/can_es_ctrl.sv
module can_es_ctrl
  import can_es_pkg::*;
#(
  parameter int unsigned N  = NSRC,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pend_any,
  input  logic [N-1:0]  grant,
  input  logic [IW-1:0] grant_idx,
  input  logic          tx_done,
  input  logic          tx_ok,
  output logic [N-1:0]  clr_vec,
  output logic          frame_req,
  output logic [7:0]    frame_code,
  output logic          reinit_req,
  output logic          busoff_seen,
  output logic          halted
);

  es_state_t    st_q;
  logic [7:0]   code_q;
  logic [N-1:0] cur_q;
  logic         recov_q;
  logic         final_q;
  logic         seen_q;

  // Named internal events
  logic sending, done_ev, recov_ok, recov_fail, pick_boff;
  assign sending    = (st_q == ST_SEND);
  assign done_ev    = sending && tx_done;
  assign recov_ok   = done_ev && recov_q && tx_ok;
  assign recov_fail = done_ev && recov_q && !tx_ok;
  assign pick_boff  = (grant_idx == IW'(P_BOFF));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      code_q  <= '0;
      cur_q   <= '0;
      recov_q <= 1'b0;
      final_q <= 1'b0;
      seen_q  <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (pend_any) begin
            cur_q <= grant;
            if (pick_boff && !seen_q) begin
              st_q    <= ST_REINIT;
              code_q  <= C_BOFF1;
              recov_q <= 1'b1;
            end else begin
              st_q    <= ST_SEND;
              code_q  <= code_of(int'(grant_idx), seen_q);
              final_q <= pick_boff;
            end
          end
        end
        ST_REINIT: st_q <= ST_SEND;
        ST_SEND: begin
          if (tx_done) begin
            cur_q <= '0;
            if (final_q) begin
              st_q <= ST_HALT;
            end else if (recov_q) begin
              recov_q <= 1'b0;
              if (tx_ok) begin
                seen_q <= 1'b1;
                st_q   <= ST_IDLE;
              end else begin
                code_q  <= C_BOFF2;
                final_q <= 1'b1;
              end
            end else begin
              st_q <= ST_IDLE;
            end
          end
        end
        default: st_q <= ST_HALT;
      endcase
    end
  end

  assign clr_vec     = done_ev ? cur_q : '0;
  assign frame_req   = sending;
  assign frame_code  = code_q;
  assign reinit_req  = (st_q == ST_REINIT);
  assign busoff_seen = seen_q;
  assign halted      = (st_q == ST_HALT);

  // R5: re-initialise request is followed by the recovery report
  a_r5_reinit_then_12: assert property (@(posedge clk) disable iff (!rst_n)
    reinit_req |=> (frame_req && frame_code == C_BOFF1));
  // R6: successful recovery sets the flag and resumes
  a_r6_recover_ok: assert property (@(posedge clk) disable iff (!rst_n)
    recov_ok |=> (busoff_seen && !halted && !frame_req));
  a_r6_seen_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    busoff_seen |=> busoff_seen);
  // R7: failed recovery report is followed by the final report
  a_r7_fail_to_13: assert property (@(posedge clk) disable iff (!rst_n)
    recov_fail |=> (frame_req && frame_code == C_BOFF2));
  // R9: halted is terminal and quiet
  a_r9_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);
  a_r9_halt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> (!frame_req && !reinit_req));

endmodule

// File: rtl/can_err_supervisor.sv
module can_err_supervisor
  import can_es_pkg::*;
#(
  parameter logic [10:0] REPORT_ID = 11'h3FF
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                err_irq,
  input  logic [FLAG_W-1:0]   err_flags,
  input  logic                sys_irq,
  input  logic                tx_done,
  input  logic                tx_ok,
  output logic                frame_req,
  output logic [10:0]         frame_id,
  output logic [7:0]          frame_code,
  output logic                reinit_req,
  output logic                busoff_seen,
  output logic                halted
);

  localparam int unsigned IW = (NSRC > 1) ? $clog2(NSRC) : 1;

  logic [NSRC-1:0] set_vec, clr_vec, pend, grant;
  logic [IW-1:0]   grant_idx;
  logic            pend_any;

  assign set_vec = halted ? '0
                 : to_prio(err_irq ? err_flags : '0, sys_irq);

  can_es_pend #(.N(NSRC)) pend_i (
    .clk(clk), .rst_n(rst_n), .flush(halted),
    .set_vec(set_vec), .clr_vec(clr_vec), .pend(pend)
  );

  can_es_prio #(.N(NSRC)) prio_i (
    .clk(clk), .rst_n(rst_n), .req(pend),
    .grant(grant), .idx(grant_idx), .any(pend_any)
  );

  can_es_ctrl #(.N(NSRC)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .pend_any(pend_any), .grant(grant),
    .grant_idx(grant_idx), .tx_done(tx_done), .tx_ok(tx_ok),
    .clr_vec(clr_vec), .frame_req(frame_req), .frame_code(frame_code),
    .reinit_req(reinit_req), .busoff_seen(busoff_seen), .halted(halted)
  );

  assign frame_id = REPORT_ID;

  // R1: a presented report holds until its transmit outcome arrives
  a_r1_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_req && !tx_done) |=> (frame_req && $stable(frame_code)));
  // R4: a system error strobe alone never moves the bus-off state
  a_r4_sys_no_boff: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_irq && !err_irq && !frame_req && !reinit_req && !halted)
      |=> ($stable(busoff_seen) && !halted));

endmodule

// File: tb/can_err_supervisor_tb_top.sv
module can_err_supervisor_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       err_irq = 1'b0;
  logic [5:0] err_flags = '0;
  logic       sys_irq = 1'b0;
  logic       mon_done = 1'b0;
  logic       stray_done = 1'b0;
  logic       tx_ok = 1'b1;
  logic       tx_done;
  logic       frame_req, reinit_req, busoff_seen, halted;
  logic [10:0] frame_id;
  logic [7:0]  frame_code;

  assign tx_done = mon_done | stray_done;

  always #5 clk = ~clk;

  can_err_supervisor dut_i (
    .clk(clk), .rst_n(rst_n), .err_irq(err_irq), .err_flags(err_flags),
    .sys_irq(sys_irq), .tx_done(tx_done), .tx_ok(tx_ok),
    .frame_req(frame_req), .frame_id(frame_id), .frame_code(frame_code),
    .reinit_req(reinit_req), .busoff_seen(busoff_seen), .halted(halted)
  );

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int nframes = 0;
  int reinit_cnt = 0;
  int reinit_cyc = -10;
  bit ok_cfg = 1'b1;
  bit done_flag = 1'b0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  task automatic chk(input bit cond, input string tag, input int act, input int exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Scoreboard monitor: every negedge with frame_req high is one report
  always @(negedge clk) begin
    cyc++;
    if (rst_n && reinit_req) begin
      reinit_cnt++;
      reinit_cyc = cyc;
    end
    if (rst_n && frame_req) begin
      nframes++;
      chk(frame_id == 11'h3FF, "R1 id", frame_id, 11'h3FF);
      if (exp_q.size() == 0) begin
        chk(1'b0, "R9/R3 unexpected report", frame_code, 0);
      end else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        chk(frame_code == e, t, frame_code, e);
        if (e == 8'h12) chk(cyc - reinit_cyc == 1, "R5 reinit precedes 0x12", cyc - reinit_cyc, 1);
      end
      mon_done <= 1'b1;
      tx_ok    <= ok_cfg;
    end else begin
      mon_done <= 1'b0;
    end
  end

  task automatic expect_code(input logic [7:0] c, input string t);
    exp_q.push_back(c);
    tag_q.push_back(t);
  endtask

  task automatic post(input logic [5:0] f, input bit sys);
    @(negedge clk);
    err_irq   = (f != 0);
    err_flags = f;
    sys_irq   = sys;
    @(negedge clk);
    err_irq   = 1'b0;
    err_flags = '0;
    sys_irq   = 1'b0;
  endtask

  task automatic settle(input string t);
    int quiet = 0;
    for (int i = 0; i < 200 && quiet < 5; i++) begin
      @(negedge clk);
      if (frame_req || reinit_req) quiet = 0; else quiet++;
    end
    chk(exp_q.size() == 0, t, exp_q.size(), 0);
    exp_q.delete();
    tag_q.delete();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!frame_req && !reinit_req && !busoff_seen && !halted, "R11 reset state",
        {frame_req, reinit_req, busoff_seen, halted}, 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : stim
    int n0;
    do_reset();

    // R2: each flag alone
    expect_code(8'h01, "R2 rx warning"); post(6'b000001, 0); settle("R2 drained");
    expect_code(8'h02, "R2 tx warning"); post(6'b000010, 0); settle("R2 drained");
    expect_code(8'h03, "R2 rx passive"); post(6'b000100, 0); settle("R2 drained");
    expect_code(8'h04, "R2 tx passive"); post(6'b001000, 0); settle("R2 drained");
    expect_code(8'h11, "R2 overflow");   post(6'b100000, 0); settle("R2 drained");

    // R3: several conditions plus system error in one go
    expect_code(8'h11, "R3 order 1"); expect_code(8'h03, "R3 order 2");
    expect_code(8'h04, "R3 order 3"); expect_code(8'h01, "R3 order 4");
    expect_code(8'h02, "R3 order 5"); expect_code(8'h20, "R3 order 6");
    post(6'b101111, 1); settle("R3 drained");

    // R4: system error alone
    expect_code(8'h20, "R4 sys code"); post(6'b0, 1); settle("R4 drained");
    chk(!busoff_seen && !halted, "R4 bus-off state kept", {busoff_seen, halted}, 0);

    // R10: failing ordinary report and stray tx_done change nothing
    ok_cfg = 1'b0;
    expect_code(8'h01, "R10 failed warning report"); post(6'b000001, 0); settle("R10 drained");
    ok_cfg = 1'b1;
    @(negedge clk); stray_done = 1'b1; @(negedge clk); stray_done = 1'b0;
    repeat (3) @(negedge clk);
    chk(!frame_req && !busoff_seen && !halted, "R10 no effect",
        {frame_req, busoff_seen, halted}, 0);

    // R5/R6: first bus-off mixed with overflow and warning, success
    n0 = reinit_cnt;
    expect_code(8'h11, "R3 ovf before bus-off"); expect_code(8'h12, "R5 recovery code");
    expect_code(8'h01, "R6 warning after recovery");
    post(6'b110001, 0); settle("R6 drained");
    chk(reinit_cnt - n0 == 1, "R5 one reinit pulse", reinit_cnt - n0, 1);
    chk(busoff_seen && !halted, "R6 seen set, running", {busoff_seen, halted}, 2'b10);
    expect_code(8'h04, "R6 normal service"); post(6'b001000, 0); settle("R6 drained");

    // R8: second bus-off
    n0 = reinit_cnt;
    expect_code(8'h13, "R8 second bus-off code"); post(6'b010000, 0); settle("R8 drained");
    chk(halted, "R8 halted", halted, 1);
    chk(reinit_cnt == n0, "R8 no reinit", reinit_cnt - n0, 0);

    // R9: halted ignores everything
    n0 = nframes;
    post(6'b111111, 1); settle("R9 drained");
    chk(nframes == n0 && halted, "R9 no reports while halted", nframes - n0, 0);

    // R7: fresh start, recovery report fails
    do_reset();
    ok_cfg = 1'b0;
    expect_code(8'h12, "R7 recovery code"); expect_code(8'h13, "R7 final code");
    post(6'b010000, 0); settle("R7 drained");
    chk(halted && !busoff_seen, "R7 halted, flag clear", {busoff_seen, halted}, 2'b01);
    ok_cfg = 1'b1;

    // R11: reset leaves the halted state
    do_reset();
    expect_code(8'h02, "R11 service after reset"); post(6'b000010, 0); settle("R11 drained");

    done_flag = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule